// File: doc/BRIEF.md
# Dual-Output Timer Waveform Generator

This block holds a free-running up-counter that wraps at a programmable period. Two compare channels each drive one waveform output. Each channel has a compare value, and a match happens when the counter is about to reach that value. In PWM mode an output goes to its active level when the counter wraps and to its inactive level on its compare match. A per-output polarity bit swaps these two events. In pulse mode each compare match starts an active pulse. The pulse length is two raised to a 3-bit exponent, counted in timer clocks.

A 7-bit settings word sets the pulse exponent, the two polarities and the two output enables. Software writes this word through a one-cycle write strobe into a shadow copy. The shadow copy becomes the live copy only at the counter wrap, so a period never runs with mixed settings. The live word is visible on a read-back port. Bit 7 of that port always reads zero.

Top module: `dual_wave_gen`

## Requirements
- R1: While reset is active, and after its release until the first wrap, `ctrl_q` is 0x00 and both `wo` and `oe` bits are 0.
- R2: The counter steps by one from 0 and wraps to 0 after the cycle in which it equals `period` (or exceeds it). In PWM mode the outputs therefore repeat every `period`+1 cycles.
- R3: A write lands in the shadow word only. `ctrl_q` shows the new value starting in the first cycle after the next wrap, and never earlier. Bit 7 of `cfg_data` is dropped, so `ctrl_q[7]` is 0.
- R4: PWM mode with polarity 0: the output is high for counter values 0 up to cmp−1 and low for counter values cmp up to `period`. This gives cmp high cycles per period.
- R5: PWM mode with polarity 1: the output is the inverse of R4, giving `period`+1−cmp high cycles per period.
- R6: In PWM mode a compare value of 0 makes the compare match win over the wrap, so the output stays at its inactive level. A compare value above `period` never matches, so the output stays at its active level.
- R7: Pulse mode (`pulse_mode`=1): each match starts an active pulse that begins at counter value cmp. It lasts 2^N cycles, where N is `ctrl_q[6:4]` (1 to 128 cycles). With polarity 0 the active level is high.
- R8: In pulse mode, polarity 1 inverts the output, so the pulse becomes 2^N low cycles.
- R9: A match that occurs while a pulse is still running restarts the full pulse length. A period shorter than the pulse therefore gives a constant active level.
- R10: `ctrl_q[0]` enables output 0 and `ctrl_q[1]` enables output 1. A disabled output has `wo`=0 and `oe`=0. An enabled output has `oe`=1.
- R11: `ctrl_q[2]` is the polarity of output 0 and `ctrl_q[3]` is the polarity of output 1. Each bit acts on its own output only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the settings shadow word |
| cfg_data | input | 8 | Settings write data (bit 7 ignored) |
| period | input | CNT_W | Wrap value of the counter |
| cmp0 | input | CNT_W | Compare value of channel 0 |
| cmp1 | input | CNT_W | Compare value of channel 1 |
| pulse_mode | input | 1 | 0 = PWM, 1 = pulse mode |
| ctrl_q | output | 8 | Live settings word |
| wo | output | 2 | Waveform outputs (bit g = channel g) |
| oe | output | 2 | Pin enables (bit g = channel g) |

## Verification
Each stimulus pattern is judged by counting high cycles over one full period in steady state.

- PWM patterns use mid-range, zero and above-period compare values under both polarities. These separate a correct duty cycle from an inverted one, and a correct match-over-wrap priority from a wrong one.
- Pulse patterns sweep all eight length codes against a long period. A compare value near the end of the period makes one pulse cross the wrap, which exposes any shift off by one. A period shorter than the pulse shows whether the pulse is restarted or extended.
- Mixed settings, such as one output inverted or one output disabled, show whether each settings bit acts on its own channel.
- A write during a long period shows whether the live word is held back until the wrap.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int NCH    = 2;
  localparam int PLEN_W = 3;

  typedef struct packed {
    logic [PLEN_W-1:0] plen;  // pulse length exponent
    logic [NCH-1:0]    pol;   // per-output polarity
    logic [NCH-1:0]    en;    // per-output enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dwg_counter.sv
module dwg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    ovf     = (cnt_q >= period);
    cnt_nxt = ovf ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R2: wrap returns to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == period) |=> (cnt_q == '0));
  // R2: below the wrap value the count steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < period) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dwg_ctrl.sv
module dwg_ctrl
  import dwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       ovf,
  output ctrl_t      act
);
  ctrl_t shd_q, shd_d, act_q, act_d;

  always_comb begin
    shd_d = we  ? ctrl_t'(wdata[CTRL_W-1:0]) : shd_q;
    act_d = ovf ? shd_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;

  // R3: the live word only moves at a wrap
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(act_q));
endmodule

// File: rtl/dwg_chan.sv
module dwg_chan
  import dwg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_mode,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [PLEN_W-1:0] plen,
  input  logic              pol,
  input  logic              en,
  output logic              wo,
  output logic              oe
);
  localparam int REM_W = (1 << PLEN_W) - 1;

  logic             match;
  logic             phase_q, phase_d;
  logic [REM_W-1:0] rem_q, rem_d, rem_load;

  always_comb begin
    match    = (cnt_nxt == cmp);
    rem_load = ~({REM_W{1'b1}} << plen);
    phase_d  = phase_q;
    rem_d    = rem_q;
    if (pulse_mode) begin
      if (match) begin
        phase_d = 1'b1;
        rem_d   = rem_load;
      end else if (phase_q && rem_q != '0) begin
        rem_d   = rem_q - 1'b1;
      end else begin
        phase_d = 1'b0;
      end
    end else begin
      if (match)    phase_d = 1'b0;
      else if (ovf) phase_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      rem_q   <= '0;
    end else begin
      phase_q <= phase_d;
      rem_q   <= rem_d;
    end
  end

  assign wo = en & (phase_q ^ pol);
  assign oe = en;

  // R4: a PWM match ends the active phase, even on a wrap cycle
  a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && match) |=> !phase_q);
  // R7: a pulse-mode match starts a pulse
  a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && match) |=> phase_q);
  // R9: a running pulse with time left keeps going
  a_r9_pulse_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && phase_q && rem_q != '0) |=> phase_q);
endmodule

// File: rtl/dual_wave_gen.sv
module dual_wave_gen
  import dwg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_data,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  input  logic             pulse_mode,
  output logic [7:0]       ctrl_q,
  output logic [1:0]       wo,
  output logic [1:0]       oe
);
  logic             ovf;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cmp_v [NCH];
  ctrl_t            act;

  assign cmp_v[0] = cmp0;
  assign cmp_v[1] = cmp1;

  dwg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .period(period), .cnt_nxt(cnt_nxt), .ovf(ovf)
  );

  dwg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_data), .ovf(ovf), .act(act)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dwg_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .ovf(ovf),
      .cnt_nxt(cnt_nxt), .cmp(cmp_v[g]), .plen(act.plen),
      .pol(act.pol[g]), .en(act.en[g]), .wo(wo[g]), .oe(oe[g])
    );
  end

  assign ctrl_q = {{(8-CTRL_W){1'b0}}, act};

  // R10: a disabled output has its pin enable low
  a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !oe[0] && !wo[0]);
endmodule

// File: tb/dual_wave_gen_tb_top.sv
module dual_wave_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [7:0] period = 8'd9;
  logic [7:0] cmp0 = '0;
  logic [7:0] cmp1 = '0;
  logic       pulse_mode = 1'b0;
  logic [7:0] ctrl_q;
  logic [1:0] wo, oe;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wave_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .period(period), .cmp0(cmp0), .cmp1(cmp1), .pulse_mode(pulse_mode),
    .ctrl_q(ctrl_q), .wo(wo), .oe(oe)
  );

  // {period, mode, ctrl, cmp0, cmp1, highs0, highs1}
  localparam logic [48:0] VEC [NV] = '{
    {8'd9,   1'b0, 8'h03, 8'd3, 8'd7,   8'd3,   8'd7},   // R4
    {8'd9,   1'b0, 8'h0F, 8'd3, 8'd7,   8'd7,   8'd3},   // R5
    {8'd9,   1'b0, 8'h07, 8'd3, 8'd7,   8'd7,   8'd7},   // R11
    {8'd9,   1'b0, 8'h03, 8'd0, 8'd12,  8'd0,   8'd10},  // R6
    {8'd9,   1'b0, 8'h0F, 8'd0, 8'd12,  8'd10,  8'd0},   // R6
    {8'd9,   1'b0, 8'h01, 8'd3, 8'd7,   8'd3,   8'd0},   // R10
    {8'd9,   1'b0, 8'h82, 8'd3, 8'd7,   8'd0,   8'd7},   // R10, R3 bit 7
    {8'd199, 1'b1, 8'h03, 8'd5, 8'd150, 8'd1,   8'd1},   // R7
    {8'd199, 1'b1, 8'h13, 8'd5, 8'd150, 8'd2,   8'd2},
    {8'd199, 1'b1, 8'h23, 8'd5, 8'd150, 8'd4,   8'd4},
    {8'd199, 1'b1, 8'h33, 8'd5, 8'd150, 8'd8,   8'd8},
    {8'd199, 1'b1, 8'h43, 8'd5, 8'd150, 8'd16,  8'd16},
    {8'd199, 1'b1, 8'h53, 8'd5, 8'd150, 8'd32,  8'd32},
    {8'd199, 1'b1, 8'h63, 8'd5, 8'd150, 8'd64,  8'd64},
    {8'd199, 1'b1, 8'h73, 8'd5, 8'd150, 8'd128, 8'd128},
    {8'd199, 1'b1, 8'h3F, 8'd5, 8'd150, 8'd192, 8'd192}, // R8
    {8'd5,   1'b1, 8'h33, 8'd2, 8'd7,   8'd6,   8'd0}    // R9
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ctrl_q in reset", int'(ctrl_q), 0);
    chk("R1 wo in reset", int'(wo), 0);
    chk("R1 oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ctrl_q after release", int'(ctrl_q), 0);
    chk("R1 oe after release", int'(oe), 0);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      int h0, h1, p;
      v = VEC[i];
      @(negedge clk);
      period = v[48:41]; pulse_mode = v[40];
      cmp0 = v[31:24]; cmp1 = v[23:16];
      wr_ctrl(v[39:32]);
      p = int'(period) + 1;
      repeat (2*p + 140) @(negedge clk);
      h0 = 0; h1 = 0;
      for (int k = 0; k < p; k++) begin
        h0 += int'(wo[0]); h1 += int'(wo[1]);
        @(negedge clk);
      end
      chk($sformatf("R4-set vec%0d out0 highs (R4 R5 R6 R7 R8 R9 R11)", i), h0, int'(v[15:8]));
      chk($sformatf("vec%0d out1 highs (R4 R5 R6 R7 R8 R9 R11)", i), h1, int'(v[7:0]));
      chk($sformatf("R10 vec%0d oe", i), int'(oe), int'(v[33:32]));
      chk($sformatf("R3 vec%0d ctrl_q", i), int'(ctrl_q), int'(v[39:32] & 8'h7F));
    end

    // R2: PWM repeat length equals period+1
    @(negedge clk);
    period = 8'd9; pulse_mode = 1'b0; cmp0 = 8'd3; cmp1 = 8'd7;
    wr_ctrl(8'h03);
    repeat (40) @(negedge clk);
    begin
      int n;
      while (!(wo[0] == 1'b0)) @(negedge clk);
      while (wo[0] == 1'b0) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (wo[0] == 1'b1);
      while (wo[0] == 1'b0) begin @(negedge clk); n++; end
      chk("R2 repeat length", n, 10);
    end

    // R3: write held back until the next wrap
    @(negedge clk);
    period = 8'd199;
    repeat (450) @(negedge clk);
    wr_ctrl(8'h0F);
    chk("R3 old value kept after write", int'(ctrl_q), 8'h03);
    repeat (201) @(negedge clk);
    chk("R3 new value after wrap", int'(ctrl_q), 8'h0F);

    summary();
  end
endmodule